// File: doc/BRIEF.md
# Set-Associative Cache Miss Profiler

This block observes a stream of memory accesses and models the tag side of a set-associative cache, without storing any data. Each accepted access carries a direction (read or write) and a byte address. The block splits the address into an in-line offset, a set index and a tag. It compares the tag against every way of the indexed set and updates least-recently-used ordering. One cycle later it reports whether the access hit.

Every miss is also sorted into one of two classes. A miss is a conflict miss when that exact byte address occurred in some earlier access of either direction. Otherwise it is a compulsory miss. Six saturating counters keep the totals for each direction and class, and they are presented on output ports. The history of seen addresses covers a bounded window that starts at address zero. A synchronous clear returns the block to its power-up state.

Top module: `cache_miss_profiler`

## Requirements
- R1: The low log2(LINE_BYTES) address bits are the in-line offset. The next log2(SETS) bits select the set, and the remaining upper bits form the tag. Two addresses that differ only in the offset share one line.
- R2: After reset or clear, every way of every set is invalid, so the first access to any line is a miss.
- R3: An access is accepted on a rising edge where in_valid and in_ready are both high. On the next cycle res_valid is high, and res_hit reports whether the tag was present in a valid way of its set. In any other cycle res_valid is low.
- R4: Replacement is LRU. A hit makes the line most recent. A miss fills an invalid way if the set has one. Otherwise it evicts the least recently used line, and the new line becomes most recent.
- R5: Reads and writes change the tag store and the recency state in the same way.
- R6: A miss is a conflict (res_conflict high) when the same byte address was accepted at any earlier time since the last reset or clear, whether by read or write and whether or not it hit. Any other miss is compulsory. res_conflict is low on a hit.
- R7: An address equal to or above HIST_BYTES is never recorded as seen, so a miss to such an address is always compulsory.
- R8: Six counters track misses: read total, read compulsory and read conflict, and the same three for writes. Each accepted access changes only the counters of its own direction. Before saturation, each total equals compulsory plus conflict.
- R9: Each counter stops at its all-ones value.
- R10: While clear is high, in_ready is low and no access is accepted. On the following cycle every counter is zero, res_valid is low, and the tag store and the history are both empty.
- R11: Outside reset and clear, in_ready is high, and one access is accepted every cycle with no gap needed between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of store, history and counters |
| in_valid | input | 1 | Access present |
| in_ready | output | 1 | Access can be accepted |
| in_write | input | 1 | 1 = write access, 0 = read access |
| in_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | Result of the access accepted in the previous cycle |
| res_hit | output | 1 | That access hit |
| res_conflict | output | 1 | That access was a conflict miss |
| res_write | output | 1 | That access was a write |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_rd_compulsory | output | CNT_W | Read compulsory misses |
| cnt_rd_conflict | output | CNT_W | Read conflict misses |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wr_compulsory | output | CNT_W | Write compulsory misses |
| cnt_wr_conflict | output | CNT_W | Write conflict misses |

## Verification
A clear and a valid access can arrive in the same cycle. The bench provokes this by raising clear at the same moment it presents an access to a line that is already cached. It then checks three things: in_ready falls at once, no result appears on the next cycle, and every counter reads zero. After that, the same address must miss as compulsory. This shows that both the history and the store were wiped and that the dropped access left no trace in either.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    typedef enum logic [1:0] {
        OUT_HIT        = 2'd0,
        OUT_COMPULSORY = 2'd1,
        OUT_CONFLICT   = 2'd2
    } outcome_e;

    typedef struct packed {
        logic      valid;
        logic      hit;
        logic      conflict;
        acc_kind_e kind;
    } result_t;

    function automatic outcome_e classify(input logic hit, input logic seen);
        if (hit)       return OUT_HIT;
        else if (seen) return OUT_CONFLICT;
        else           return OUT_COMPULSORY;
    endfunction

endpackage

// File: rtl/cmp_tag_store.sv
module cmp_tag_store #(
    parameter int SETS  = 1024,
    parameter int WAYS  = 2,
    parameter int TAG_W = 18,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] inv_way;
    logic             any_inv;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] sel_way;

    always_comb begin
        hit_way = '0;
        inv_way = '0;
        any_inv = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = vld_q[set_idx][w] && (tag_q[set_idx][w] == tag);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
            if (!vld_q[set_idx][w]) begin
                inv_way = WAY_W'(w);
                any_inv = 1'b1;
            end
        end
    end

    assign hit     = |hit_vec;
    assign sel_way = hit ? hit_way : (any_inv ? inv_way : lru_way);

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (en) begin
            vld_q[set_idx][sel_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (en && !clr) tag_q[set_idx][sel_way] <= tag;
    end

    generate
        if (WAYS == 2) begin : g_bit
            logic [SETS-1:0] mru_q;
            assign lru_way = WAY_W'(~mru_q[set_idx]);
            always_ff @(posedge clk) begin
                if (clr)     mru_q <= '0;
                else if (en) mru_q[set_idx] <= sel_way[0];
            end
        end else begin : g_age
            logic [WAY_W-1:0] age_q [SETS][WAYS];
            always_comb begin
                lru_way = '0;
                for (int w = 0; w < WAYS; w++) begin
                    if (age_q[set_idx][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
                end
            end
            always_ff @(posedge clk) begin
                if (clr) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++)
                            age_q[s][w] <= WAY_W'(w);
                end else if (en) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (WAY_W'(w) == sel_way)
                            age_q[set_idx][w] <= '0;
                        else if (age_q[set_idx][w] < age_q[set_idx][sel_way])
                            age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cmp_history.sv
module cmp_history #(
    parameter int ADDR_W     = 32,
    parameter int HIST_BYTES = 2048,
    localparam int HIST_W = $clog2(HIST_BYTES)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              seen
);
    logic [HIST_BYTES-1:0] seen_q;
    logic                  in_win;

    assign in_win = addr < ADDR_W'(HIST_BYTES);
    assign seen   = in_win && seen_q[addr[HIST_W-1:0]];

    always_ff @(posedge clk) begin
        if (clr)                 seen_q <= '0;
        else if (en && in_win)   seen_q[addr[HIST_W-1:0]] <= 1'b1;
    end

endmodule

// File: rtl/cmp_sat_counter.sv
module cmp_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (clr)                        value <= '0;
        else if (inc && (value != '1))  value <= value + 1'b1;
    end
endmodule

// File: rtl/cache_miss_profiler.sv
module cache_miss_profiler
    import cmp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CAPACITY   = 32768,
    parameter int LINE_BYTES = 16,
    parameter int WAYS       = 2,
    parameter int HIST_BYTES = 2048,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_conflict,
    output logic              res_write,
    output logic [CNT_W-1:0]  cnt_rd_miss,
    output logic [CNT_W-1:0]  cnt_rd_compulsory,
    output logic [CNT_W-1:0]  cnt_rd_conflict,
    output logic [CNT_W-1:0]  cnt_wr_miss,
    output logic [CNT_W-1:0]  cnt_wr_compulsory,
    output logic [CNT_W-1:0]  cnt_wr_conflict
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SETS  = CAPACITY / (LINE_BYTES * WAYS);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int NCNT  = 6;

    logic             clr;
    logic             fire;
    logic             hit;
    logic             seen;
    outcome_e         outcome;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;
    result_t          res_q;
    logic [NCNT-1:0]  inc;
    logic [CNT_W-1:0] cnt [NCNT];

    assign clr      = rst | clear;
    assign in_ready = ~clr;
    assign fire     = in_valid & in_ready;
    assign set_idx  = in_addr[OFF_W +: SET_W];
    assign tag      = in_addr[ADDR_W-1 -: TAG_W];

    cmp_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .clr(clr), .en(fire), .set_idx(set_idx), .tag(tag), .hit(hit)
    );

    cmp_history #(.ADDR_W(ADDR_W), .HIST_BYTES(HIST_BYTES)) u_hist (
        .clk(clk), .clr(clr), .en(fire), .addr(in_addr), .seen(seen)
    );

    assign outcome = classify(hit, seen);

    always_comb begin
        inc[0] = fire && !in_write && (outcome != OUT_HIT);
        inc[1] = fire && !in_write && (outcome == OUT_COMPULSORY);
        inc[2] = fire && !in_write && (outcome == OUT_CONFLICT);
        inc[3] = fire &&  in_write && (outcome != OUT_HIT);
        inc[4] = fire &&  in_write && (outcome == OUT_COMPULSORY);
        inc[5] = fire &&  in_write && (outcome == OUT_CONFLICT);
    end

    generate
        for (genvar i = 0; i < NCNT; i++) begin : g_cnt
            cmp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk(clk), .clr(clr), .inc(inc[i]), .value(cnt[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            res_q <= '0;
        end else begin
            res_q.valid <= fire;
            if (fire) begin
                res_q.hit      <= (outcome == OUT_HIT);
                res_q.conflict <= (outcome == OUT_CONFLICT);
                res_q.kind     <= in_write ? ACC_WRITE : ACC_READ;
            end
        end
    end

    assign res_valid         = res_q.valid;
    assign res_hit           = res_q.hit;
    assign res_conflict      = res_q.conflict;
    assign res_write         = (res_q.kind == ACC_WRITE);
    assign cnt_rd_miss       = cnt[0];
    assign cnt_rd_compulsory = cnt[1];
    assign cnt_rd_conflict   = cnt[2];
    assign cnt_wr_miss       = cnt[3];
    assign cnt_wr_compulsory = cnt[4];
    assign cnt_wr_conflict   = cnt[5];

endmodule

// File: rtl/cmp_profiler_chk.sv
module cmp_profiler_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clear,
    input logic             in_valid,
    input logic             in_ready,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_conflict,
    input logic             res_write,
    input logic [CNT_W-1:0] rd_miss,
    input logic [CNT_W-1:0] rd_comp,
    input logic [CNT_W-1:0] rd_conf,
    input logic [CNT_W-1:0] wr_miss,
    input logic [CNT_W-1:0] wr_comp,
    input logic [CNT_W-1:0] wr_conf
);
    // R3
    result_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> res_valid);

    // R3
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !res_valid);

    // R6
    hit_not_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> !res_conflict);

    // R8
    rd_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_miss != '1) |-> (rd_miss == rd_comp + rd_conf));

    // R8
    wr_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_miss != '1) |-> (wr_miss == wr_comp + wr_conf));

    // R8
    write_keeps_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_write) |-> $stable(rd_miss));

    // R8
    read_keeps_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_write) |-> $stable(wr_miss));

    // R9
    no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (rd_miss >= $past(rd_miss)) && (wr_miss >= $past(wr_miss)));

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!res_valid && rd_miss == '0 && wr_miss == '0));

endmodule

bind cache_miss_profiler cmp_profiler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid), .in_ready(in_ready),
    .res_valid(res_valid), .res_hit(res_hit), .res_conflict(res_conflict),
    .res_write(res_write),
    .rd_miss(cnt_rd_miss), .rd_comp(cnt_rd_compulsory), .rd_conf(cnt_rd_conflict),
    .wr_miss(cnt_wr_miss), .wr_comp(cnt_wr_compulsory), .wr_conf(cnt_wr_conflict)
);

// File: tb/sim_cache_miss_profiler.sv
`timescale 1ns/1ps
module sim_cache_miss_profiler;
    localparam int HB = 256;
    localparam int C1 = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic in_valid = 1'b0;
    logic in_write = 1'b0;
    logic [31:0] in_addr = '0;

    logic rdy0, rv0, rh0, rc0, rw0;
    logic rdy1, rv1, rh1, rc1, rw1;
    logic [31:0] a0 [6];
    logic [C1-1:0] a1 [6];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cache_miss_profiler #(.ADDR_W(32), .CAPACITY(128), .LINE_BYTES(16), .WAYS(2),
        .HIST_BYTES(HB), .CNT_W(32)) u0 (
        .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid), .in_ready(rdy0),
        .in_write(in_write), .in_addr(in_addr), .res_valid(rv0), .res_hit(rh0),
        .res_conflict(rc0), .res_write(rw0),
        .cnt_rd_miss(a0[0]), .cnt_rd_compulsory(a0[1]), .cnt_rd_conflict(a0[2]),
        .cnt_wr_miss(a0[3]), .cnt_wr_compulsory(a0[4]), .cnt_wr_conflict(a0[5]));

    cache_miss_profiler #(.ADDR_W(32), .CAPACITY(256), .LINE_BYTES(16), .WAYS(4),
        .HIST_BYTES(HB), .CNT_W(C1)) u1 (
        .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid), .in_ready(rdy1),
        .in_write(in_write), .in_addr(in_addr), .res_valid(rv1), .res_hit(rh1),
        .res_conflict(rc1), .res_write(rw1),
        .cnt_rd_miss(a1[0]), .cnt_rd_compulsory(a1[1]), .cnt_rd_conflict(a1[2]),
        .cnt_wr_miss(a1[3]), .cnt_wr_compulsory(a1[4]), .cnt_wr_conflict(a1[5]));

    // Reference: per model, per set, a recency list (index 0 = most recent, -1 = empty)
    int    lst [2][4][4];
    bit    seen [2][HB];
    longint ecnt [2][6];
    int    nways [2] = '{2, 4};
    longint cmax [2] = '{64'h0000_0000_FFFF_FFFF, 64'd7};
    bit    eh [2];
    bit    ec [2];

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) for (int p = 0; p < 4; p++) lst[m][s][p] = -1;
            for (int b = 0; b < HB; b++) seen[m][b] = 1'b0;
            for (int k = 0; k < 6; k++) ecnt[m][k] = 0;
        end
    endtask

    task automatic bump(input int m, input int k);
        if (ecnt[m][k] < cmax[m]) ecnt[m][k]++;
    endtask

    task automatic model_access(input int m, input bit wr, input int addr);
        int st, tg, pos, base;
        st = (addr >> 4) & 3;
        tg = addr >>> (m == 0 ? 6 : 6);
        pos = -1;
        for (int p = 0; p < nways[m]; p++) if (lst[m][st][p] == tg) pos = p;
        eh[m] = (pos >= 0);
        if (pos < 0) pos = nways[m] - 1;
        for (int p = pos; p > 0; p--) lst[m][st][p] = lst[m][st][p-1];
        lst[m][st][0] = tg;
        ec[m] = !eh[m] && addr < HB && seen[m][addr];
        base = wr ? 3 : 0;
        if (!eh[m]) begin
            bump(m, base);
            bump(m, ec[m] ? base + 2 : base + 1);
        end
        if (addr < HB) seen[m][addr] = 1'b1;
    endtask

    task automatic check_counts(input string req);
        for (int k = 0; k < 6; k++) begin
            check({req, " cnt0"}, longint'(a0[k]), ecnt[0][k]);
            check({req, " cnt1"}, longint'(a1[k]), ecnt[1][k]);
        end
    endtask

    // drive at a falling edge, result checked at the next falling edge
    task automatic acc(input string req, input bit wr, input int addr);
        in_valid = 1'b1;
        in_write = wr;
        in_addr  = addr;
        model_access(0, wr, addr);
        model_access(1, wr, addr);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid0"}, rv0, 1);
        check({req, " valid1"}, rv1, 1);
        check({req, " hit0"}, rh0, eh[0]);
        check({req, " hit1"}, rh1, eh[1]);
        check({req, " conflict0"}, rc0, ec[0]);
        check({req, " conflict1"}, rc1, ec[1]);
        check({req, " kind"}, rw0, wr);
        check_counts(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit [15:0] lf;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state, R11 ready
        check("R10 reset res_valid", rv0, 0);
        check("R11 ready0", rdy0, 1);
        check("R11 ready1", rdy1, 1);
        check_counts("R10 reset");

        // R2: first touch of every set misses as compulsory
        for (int s = 0; s < 4; s++) acc("R2", 1'b0, s * 16);
        // R1: offset-only differences stay on one line
        acc("R1", 1'b0, 4);
        acc("R1", 1'b1, 'h3F);
        // R4: LRU ordering in set 0
        acc("R4", 1'b0, 'h40);
        acc("R4", 1'b0, 'h00);
        acc("R4", 1'b0, 'h80);
        acc("R4", 1'b0, 'h40);
        acc("R4", 1'b0, 'hC0);
        acc("R4", 1'b0, 'h00);
        // R5: a write fills the line a read then hits
        acc("R5", 1'b1, 'h90);
        acc("R5", 1'b0, 'h94);
        acc("R6", 1'b1, 'h94);
        @(negedge clk);
        check("R3 idle", rv0, 0);
        // R7: addresses beyond the window never count as seen
        acc("R7", 1'b0, 'h300);
        acc("R7", 1'b0, 'h340);
        acc("R7", 1'b0, 'h380);
        acc("R7", 1'b0, 'h3C0);
        acc("R7", 1'b0, 'h400);
        acc("R7", 1'b0, 'h300);
        check("R7 no conflict", rc0, 0);
        // R6 R9 R11: back-to-back mixed sweep
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            acc("R6 R8 R9 R11 sweep", lf[9], int'(lf[8:0]));
        end
        check("R9 saturate rd", longint'(a1[0]), 7);
        check("R9 saturate wr", longint'(a1[3]), 7);

        // R10: clear coinciding with an access to a cached line
        acc("R10 pre", 1'b0, 'h10);
        acc("R10 pre", 1'b0, 'h10);
        clear = 1'b1;
        in_valid = 1'b1;
        in_write = 1'b0;
        in_addr = 'h10;
        #1;
        check("R10 ready low", rdy0, 0);
        @(negedge clk);
        clear = 1'b0;
        in_valid = 1'b0;
        model_clear();
        check("R10 dropped", rv0, 0);
        check("R10 dropped1", rv1, 0);
        check_counts("R10 cleared");
        acc("R10 after", 1'b0, 'h10);
        check("R10 compulsory", longint'(a0[1]), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule